// File: doc/BRIEF.md
# Wide-Range Gate Delay

This block delays a gate signal by an absolute time. The time can be as short as about 50 microseconds or longer than fifteen seconds. The gate input is already synchronised to the clock. The delay is set by a panel knob value plus a control-voltage value, both already converted to 10-bit codes. Their saturated sum is a single code. That code is mapped exponentially onto a tick count, so both short and long delays get usable resolution. One tick is one microsecond, made from the system clock by a prescaler.

The rising edge and the falling edge of the input are each delayed by the same latched amount, so the output keeps the input's high time. A minimum output width is enforced by stretching short pulses. Each channel has one pending delayed pulse. A new rising edge that arrives while a delay is pending restarts the timer, and the latest edge wins.

Top module: `gate_delay`

## Requirements
- R1: After reset, `gate_out` is low and no delayed edge is pending.
- R2: The delay code is `knob_code + cv_code`, saturated at 1023.
- R3: The code is split into an exponent (bits 9:5) and a mantissa (bits 4:0). The delay is (32 + mantissa) * 2^exponent + 18 ticks, saturated at 2^CNT_W - 1.
- R4: `gate_out` rises exactly D ticks after the first clock edge that samples `gate_in` high, where D is the delay for the code present at that edge.
- R5: When the input high time is at least MIN_W ticks, the output high time equals the input high time.
- R6: When the input high time is shorter than MIN_W ticks, the output stays high for exactly MIN_W ticks.
- R7: A new rising edge during a pending rise delay discards the pending edge and restarts timing with the code current at the new edge. Only one output pulse results.
- R8: The delay is latched at the rising edge, so code changes while the pulse is in flight alter neither its rise time nor its width.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| gate_in | input | 1 | Synchronised input gate |
| knob_code | input | 10 | Panel delay setting |
| cv_code | input | 10 | Control-input delay setting |
| gate_out | output | 1 | Delayed gate |

## Verification
The bench runs with one tick per clock. Under that setting, the output's rising edge appears on the clock edge D cycles after the first edge that samples the input high. Its falling edge comes D cycles after the first edge that samples the input low, or MIN_W cycles after the rise, whichever is later. Inputs change just after a falling clock edge, and the output is sampled at every falling edge. The first high sample is therefore due D+1 samples after the drive, and the high count equals the expected width exactly. The bench computes D arithmetically from the knob and control codes for a sweep of exponents and mantissas.

// File: rtl/gate_delay.sv
module gate_delay #(
  parameter int CODE_W   = 10,
  parameter int MANT_W   = 5,
  parameter int CNT_W    = 25,
  parameter int OFFSET   = 18,
  parameter int TICK_DIV = 50,
  parameter int MIN_W    = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              gate_in,
  input  logic [CODE_W-1:0] knob_code,
  input  logic [CODE_W-1:0] cv_code,
  output logic              gate_out
);
  localparam int HW = $clog2(MIN_W + 1);
  localparam logic [63:0] MAXC = (64'd1 << CNT_W) - 64'd1;

  logic [CODE_W:0]   sum;
  logic [CODE_W-1:0] code;
  logic [63:0]       raw;
  logic [CNT_W-1:0]  dly, d_hold, r_cnt, f_cnt;
  logic [HW-1:0]     hi_cnt;
  logic g_q, r_act, f_act, f_req, out_q, tick;
  logic rise, fall, rise_fire, fall_fire, drop;

  assign sum  = {1'b0, knob_code} + {1'b0, cv_code};
  assign code = sum[CODE_W] ? '1 : sum[CODE_W-1:0];
  assign raw  = (64'({1'b1, code[MANT_W-1:0]}) << code[CODE_W-1:MANT_W]) + 64'(OFFSET);
  assign dly  = (raw > MAXC) ? MAXC[CNT_W-1:0] : raw[CNT_W-1:0];

  generate
    if (TICK_DIV == 1) begin : g_notick
      assign tick = 1'b1;
    end else begin : g_pre
      localparam int PW = $clog2(TICK_DIV);
      logic [PW-1:0] pre;
      assign tick = (pre == PW'(TICK_DIV - 1));
      always_ff @(posedge clk)
        if (!rst_n || tick) pre <= '0;
        else pre <= pre + 1'b1;
    end
  endgenerate

  assign rise      = gate_in & ~g_q;
  assign fall      = ~gate_in & g_q;
  assign rise_fire = r_act && tick && (r_cnt == CNT_W'(1));
  assign fall_fire = f_act && tick && (f_cnt == CNT_W'(1));
  assign drop      = out_q && tick && (fall_fire || f_req) && (hi_cnt >= HW'(MIN_W - 1));
  assign gate_out  = out_q;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      g_q <= 1'b0; r_act <= 1'b0; f_act <= 1'b0; f_req <= 1'b0; out_q <= 1'b0;
      r_cnt <= '0; f_cnt <= '0; d_hold <= '0; hi_cnt <= '0;
    end else begin
      g_q <= gate_in;
      if (rise) begin
        r_act <= 1'b1; r_cnt <= dly; d_hold <= dly;
      end else if (r_act && tick) begin
        r_cnt <= r_cnt - 1'b1;
        if (r_cnt == CNT_W'(1)) r_act <= 1'b0;
      end
      if (fall) begin
        f_act <= 1'b1; f_cnt <= d_hold;
      end else if (f_act && tick) begin
        f_cnt <= f_cnt - 1'b1;
        if (f_cnt == CNT_W'(1)) f_act <= 1'b0;
      end
      if (rise_fire) begin
        out_q <= 1'b1; hi_cnt <= '0; f_req <= 1'b0;
      end else if (drop) begin
        out_q <= 1'b0; f_req <= 1'b0;
      end else begin
        if (fall_fire && out_q) f_req <= 1'b1;
        if (out_q && tick && hi_cnt < HW'(MIN_W - 1)) hi_cnt <= hi_cnt + 1'b1;
      end
    end
  end

  p_reset_idle_r1: assert property (@(posedge clk) !rst_n |=> (!out_q && !r_act && !f_act));
  p_dly_range_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dly >= CNT_W'(OFFSET + 32) || 64'(dly) == MAXC);
  p_rise_load_r4: assert property (@(posedge clk) disable iff (!rst_n)
    rise |=> (r_act && r_cnt == $past(dly)));
  p_fire_out_r4: assert property (@(posedge clk) disable iff (!rst_n) rise_fire |=> out_q);
  p_no_underflow_r4: assert property (@(posedge clk) disable iff (!rst_n) r_act |-> r_cnt != '0);
  p_min_width_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_q && hi_cnt < HW'(MIN_W - 1)) |=> out_q);
  p_fall_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (f_act && !fall) |=> $stable(f_act) || f_cnt == '0 || $past(f_cnt) == CNT_W'(1));
endmodule

// File: tb/tb_gate_delay.sv
module tb_gate_delay;
  localparam int MINW = 20;
  logic clk = 1'b0, rst_n = 1'b0, gate_in = 1'b0, gate_out;
  logic [9:0] knob_code = '0, cv_code = '0;
  int checks = 0, failures = 0, cyc = 0, rise_t = 0, fall_t = 0, nrise = 0;
  logic prev = 1'b0, fell = 1'b0, finished = 1'b0;

  gate_delay #(.CNT_W(12), .TICK_DIV(1), .MIN_W(MINW)) dut (
    .clk(clk), .rst_n(rst_n), .gate_in(gate_in),
    .knob_code(knob_code), .cv_code(cv_code), .gate_out(gate_out));

  always #10 clk = ~clk;

  always @(negedge clk) begin
    cyc++;
    if (gate_out && !prev) begin rise_t = cyc; nrise++; end
    if (!gate_out && prev) begin fall_t = cyc; fell = 1'b1; end
    prev = gate_out;
  end

  function automatic int exp_d(int k, int c);
    int s, e, m;
    longint v;
    s = k + c;
    if (s > 1023) s = 1023;
    e = s >> 5;
    m = s & 31;
    v = (longint'(32 + m) << e) + 18;
    if (v > 4095) v = 4095;
    return int'(v);
  endfunction

  task automatic check(string req, int act, int expv);
    checks++;
    if (act != expv) begin
      failures++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, expv);
    end
  endtask

  task automatic wait_fall();
    for (int i = 0; i < 6000 && !fell; i++) @(negedge clk);
    repeat (4) @(negedge clk);
  endtask

  task automatic run_pulse(int k, int c, int w, int k2, string tag);
    int t0, d, wexp;
    d = exp_d(k, c);
    wexp = (w >= MINW) ? w : MINW;
    knob_code = 10'(k); cv_code = 10'(c);
    fell = 1'b0; nrise = 0;
    @(negedge clk); #1;
    gate_in = 1'b1; t0 = cyc;
    for (int i = 0; i < w; i++) begin
      @(negedge clk); #1;
      if (i == 2 && k2 >= 0) knob_code = 10'(k2);
    end
    gate_in = 1'b0;
    wait_fall();
    check({tag, " R4 rise delay"}, rise_t - t0, d + 1);
    check({tag, (w >= MINW) ? " R5 width" : " R6 min width"}, fall_t - rise_t, wexp);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1 out low in reset", int'(gate_out), 0);
    #1 rst_n = 1'b1;
    repeat (30) @(negedge clk);
    check("R1 idle after reset", nrise, 0);

    for (int e = 0; e < 7; e++)
      for (int mi = 0; mi < 3; mi++) begin
        int m = (mi == 0) ? 0 : (mi == 1) ? 7 : 31;
        run_pulse(e * 32 + m, 0, 33, -1, "R3 sweep");
        run_pulse(0, e * 32 + m, 7, -1, "R3 cv sweep");
      end

    run_pulse(20, 40, 25, -1, "R2 sum");
    run_pulse(700, 700, 25, -1, "R2 sum saturation");
    run_pulse(224, 0, 30, -1, "R3 count saturation");
    run_pulse(10, 0, 40, 300, "R8 code change in flight");
    run_pulse(10, 0, 5, 300, "R8 short pulse code change");

    begin : r7_restart
      int t0b;
      fell = 1'b0; nrise = 0;
      knob_code = 10'd0; cv_code = 10'd0;
      @(negedge clk); #1 gate_in = 1'b1;
      repeat (5) @(negedge clk);
      #1 gate_in = 1'b0;
      repeat (5) @(negedge clk);
      #1 knob_code = 10'd32; gate_in = 1'b1; t0b = cyc;
      repeat (30) @(negedge clk);
      #1 gate_in = 1'b0;
      wait_fall();
      check("R7 restart rise time", rise_t - t0b, exp_d(32, 0) + 1);
      check("R7 single output pulse", nrise, 1);
      check("R7 width of latest pulse", fall_t - rise_t, 30);
    end

    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #(20 * 190000);
    if (!finished) begin
      checks++; failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule